// File: doc/BRIEF.md
# Record/Playback Loop Sequencer

This controller runs the closed record-then-playback cycle of a wavefront-conjugation setup. Once started, it first takes a single reference frame with the sample beam shuttered. It then enters a loop in which each iteration is paced by the recording camera. At the camera's exposure start the display mirrors are held dark while the interference frame is exposed and read out. The controller waits for the downstream logic to report that every pixel's phase has been resolved, and only then starts the phase-map transfer to the mirror array. When the link reports completion, the map is shown for a programmable number of clock cycles. During that time the sample shutter is closed and the observation camera and photodiode recorder are gated on.

For each iteration the block also measures, in clock cycles, the time from the camera exposure start to the start of playback, and holds the result on an output. A stop request lets the running iteration finish and then parks the controller in idle.

States: `ST_IDLE` (parked), `ST_REF` (reference frame), `ST_ARMED` (waiting for exposure), `ST_CAPTURE` (frame exposing/transferring), `ST_PROCESS` (waiting for phase ready), `ST_KICK` (one-cycle transfer launch), `ST_SEND` (waiting for link completion), `ST_PLAY` (map displayed). Transitions:
- IDLE→REF on start.
- REF→ARMED on camera transfer done.
- ARMED→IDLE on a stop (pending or present).
- ARMED→CAPTURE on exposure high with no stop.
- CAPTURE→PROCESS on camera transfer done.
- PROCESS→KICK on phase ready.
- KICK→SEND unconditionally.
- SEND→PLAY on link done.
- PLAY→ARMED on the last playback cycle, or PLAY→IDLE if a stop is pending.

Top module: `pc_loop_sequencer`

## Requirements
- R1: While reset is low and after it releases, the mirror-dark command is 1, the shutter-open output is 1, transfer start, observer trigger and photodiode gate are 0, and the latency output is 0.
- R2: A start pulse in idle begins the reference frame: shutter-open goes to 0 with mirrors dark until a camera transfer-done pulse, after which the shutter reopens (armed) with mirrors still dark.
- R3: In the armed state a high exposure input begins an iteration; mirrors stay dark and the shutter stays open through capture and processing.
- R4: The transfer start output is a single-cycle pulse issued only after both the frame's transfer-done and the phase-ready flag have been seen; the mirror-dark command drops in that same cycle.
- R5: The shutter-open output is 0 from the transfer-start cycle through the last playback cycle.
- R6: Playback begins on the clock edge that samples link-done; it lasts P cycles, where P is the playback length input sampled on that edge (a value of 0 is treated as 1). The controller then returns to armed, with mirrors dark and shutter open.
- R7: The observer trigger and photodiode gate are both 1 in exactly the playback cycles, and both are 0 in the first cycle after playback.
- R8: The latency output is updated on entry to playback to the number of clock edges from the edge that sampled exposure in the armed state to the edge that entered playback. It saturates at all ones and holds its value otherwise.
- R9: A stop pulse is remembered. The running iteration completes and the controller then goes idle; a stop seen while armed goes idle at once. In idle the camera and phase-ready inputs start nothing, and only a new start leads, via a reference frame, back into the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, used in idle |
| stop_i | input | 1 | Stop request pulse |
| cam_expose_i | input | 1 | Recording camera exposure active |
| cam_xfer_done_i | input | 1 | Recording camera frame transfer done pulse |
| map_ready_i | input | 1 | All pixels' binary phase resolved |
| link_done_i | input | 1 | Phase-map transfer to the display finished |
| play_cycles_i | input | PLAY_W | Playback duration in clock cycles |
| mirrors_off_o | output | 1 | Force every display mirror off |
| link_start_o | output | 1 | One-cycle start of phase-map transfer |
| shutter_open_o | output | 1 | Sample-beam fast shutter open (1) / closed (0) |
| obs_trig_o | output | 1 | Observation camera exposure trigger |
| apd_gate_o | output | 1 | Photodiode recording gate |
| lat_cycles_o | output | LAT_W | Last measured exposure-to-playback latency |

## Verification
Every cycle, the assertions check several properties. The transfer start never lasts two cycles. Whenever the transfer is launched or the map is shown, the shutter is closed and the mirrors are released. Playback is entered only from the transfer wait. The first cycle after playback is dark and open. The latency register moves only when playback starts. The bench scenarios are needed for the rest: the playback length with its zero case, the exact latency value with saturation, the reference frame, and stop handling. They show that the stop finishes the iteration and that an idle controller ignores camera events.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REF,
        ST_ARMED,
        ST_CAPTURE,
        ST_PROCESS,
        ST_KICK,
        ST_SEND,
        ST_PLAY
    } seq_state_e;

endpackage

// File: rtl/pc_play_timer.sv
module pc_play_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem_q;

    // Length zero is promoted to a single cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= (len == '0) ? ONE : len;
        end else if (run && rem_q != '0) begin
            rem_q <= rem_q - ONE;
        end
    end

    assign last = (rem_q == ONE);

endmodule

// File: rtl/pc_lat_meter.sv
module pc_lat_meter #(
    parameter int LAT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic             capture,
    output logic [LAT_W-1:0] lat
);

    localparam logic [LAT_W-1:0] ONE  = LAT_W'(1);
    localparam logic [LAT_W-1:0] SATV = '1;

    logic [LAT_W-1:0] cnt_q;

    // The edge that sees exposure counts as the first edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= ONE;
        end else if (run && cnt_q != SATV) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat <= '0;
        end else if (capture) begin
            lat <= cnt_q;
        end
    end

endmodule

// File: rtl/pc_loop_sequencer.sv
module pc_loop_sequencer
    import pc_seq_pkg::*;
#(
    parameter int PLAY_W = 24,
    parameter int LAT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              cam_expose_i,
    input  logic              cam_xfer_done_i,
    input  logic              map_ready_i,
    input  logic              link_done_i,
    input  logic [PLAY_W-1:0] play_cycles_i,
    output logic              mirrors_off_o,
    output logic              link_start_o,
    output logic              shutter_open_o,
    output logic              obs_trig_o,
    output logic              apd_gate_o,
    output logic [LAT_W-1:0]  lat_cycles_o
);

    seq_state_e state_q, state_d;
    logic       stop_q;
    logic       stop_any;
    logic       play_last;
    logic       iter_go;
    logic       play_enter;
    logic       meas_run;

    assign stop_any   = stop_q | stop_i;
    assign iter_go    = (state_q == ST_ARMED) && cam_expose_i && !stop_any;
    assign play_enter = (state_q == ST_SEND) && link_done_i;
    assign meas_run   = (state_q == ST_CAPTURE) || (state_q == ST_PROCESS) ||
                        (state_q == ST_KICK)    || (state_q == ST_SEND);

    // Pending stop: held until the controller parks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            stop_q <= 1'b0;
        end else if (stop_i) begin
            stop_q <= 1'b1;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_REF;
            ST_REF:     if (cam_xfer_done_i) state_d = ST_ARMED;
            ST_ARMED: begin
                if (stop_any)          state_d = ST_IDLE;
                else if (cam_expose_i) state_d = ST_CAPTURE;
            end
            ST_CAPTURE: if (cam_xfer_done_i) state_d = ST_PROCESS;
            ST_PROCESS: if (map_ready_i) state_d = ST_KICK;
            ST_KICK:    state_d = ST_SEND;
            ST_SEND:    if (link_done_i) state_d = ST_PLAY;
            ST_PLAY: begin
                if (play_last) state_d = stop_any ? ST_IDLE : ST_ARMED;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        mirrors_off_o  = 1'b1;
        link_start_o   = 1'b0;
        shutter_open_o = 1'b1;
        obs_trig_o     = 1'b0;
        apd_gate_o     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ARMED, ST_CAPTURE, ST_PROCESS: begin
            end
            ST_REF: begin
                shutter_open_o = 1'b0;
            end
            ST_KICK: begin
                mirrors_off_o  = 1'b0;
                link_start_o   = 1'b1;
                shutter_open_o = 1'b0;
            end
            ST_SEND: begin
                mirrors_off_o  = 1'b0;
                shutter_open_o = 1'b0;
            end
            ST_PLAY: begin
                mirrors_off_o  = 1'b0;
                shutter_open_o = 1'b0;
                obs_trig_o     = 1'b1;
                apd_gate_o     = 1'b1;
            end
        endcase
    end

    pc_play_timer #(
        .CNT_W (PLAY_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (play_enter),
        .run   (state_q == ST_PLAY),
        .len   (play_cycles_i),
        .last  (play_last)
    );

    pc_lat_meter #(
        .LAT_W (LAT_W)
    ) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (iter_go),
        .run     (meas_run),
        .capture (play_enter),
        .lat     (lat_cycles_o)
    );

endmodule

// File: rtl/pc_loop_sequencer_chk.sv
module pc_loop_sequencer_chk #(
    parameter int LAT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mirrors_off_o,
    input logic             link_start_o,
    input logic             shutter_open_o,
    input logic             obs_trig_o,
    input logic             apd_gate_o,
    input logic [LAT_W-1:0] lat_cycles_o
);

    p_kick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        link_start_o |=> !link_start_o);

    p_kick_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        link_start_o |-> (!mirrors_off_o && !shutter_open_o && !obs_trig_o));

    p_play_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        obs_trig_o |-> (!shutter_open_o && !mirrors_off_o));

    p_play_from_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(obs_trig_o) |-> $past(!mirrors_off_o && !link_start_o));

    p_after_play_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(obs_trig_o) |-> (mirrors_off_o && shutter_open_o && !apd_gate_o));

    p_lat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(obs_trig_o) |-> $stable(lat_cycles_o));

endmodule

bind pc_loop_sequencer pc_loop_sequencer_chk #(.LAT_W(LAT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mirrors_off_o  (mirrors_off_o),
    .link_start_o   (link_start_o),
    .shutter_open_o (shutter_open_o),
    .obs_trig_o     (obs_trig_o),
    .apd_gate_o     (apd_gate_o),
    .lat_cycles_o   (lat_cycles_o)
);

// File: tb/pc_loop_sequencer_test.sv
module pc_loop_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int PW   = 8;
    localparam int LW   = 6;
    localparam int LMAX = 63;
    localparam int WD   = 20000;
    localparam int NV   = 6;
    // exposure, xfer gap, processing gap, link gap (>=1), playback length
    localparam int VEC [NV][5] = '{
        '{1, 2, 0, 1, 3},
        '{4, 0, 3, 2, 1},
        '{2, 5, 1, 4, 0},
        '{3, 1, 2, 1, 7},
        '{1, 0, 0, 1, 2},
        '{6, 40, 20, 10, 2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, stop_i = 1'b0;
    logic          cam_expose_i = 1'b0, cam_xfer_done_i = 1'b0;
    logic          map_ready_i = 1'b0, link_done_i = 1'b0;
    logic [PW-1:0] play_cycles_i = '0;
    logic          mirrors_off_o, link_start_o, shutter_open_o;
    logic          obs_trig_o, apd_gate_o;
    logic [LW-1:0] lat_cycles_o;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;

    pc_loop_sequencer #(.PLAY_W(PW), .LAT_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .cam_expose_i(cam_expose_i), .cam_xfer_done_i(cam_xfer_done_i),
        .map_ready_i(map_ready_i), .link_done_i(link_done_i),
        .play_cycles_i(play_cycles_i), .mirrors_off_o(mirrors_off_o),
        .link_start_o(link_start_o), .shutter_open_o(shutter_open_o),
        .obs_trig_o(obs_trig_o), .apd_gate_o(apd_gate_o),
        .lat_cycles_o(lat_cycles_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WD) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    // One iteration from the armed state; a stop pulse is optional.
    task automatic run_iter(input int e, input int x, input int p,
                            input int l, input int pl, input bit stp);
        int t0, t1, n, na, w;
        play_cycles_i = PW'(pl);
        cam_expose_i = 1'b1;
        t0 = cyc + 1;
        repeat (e) @(negedge clk);
        cam_expose_i = 1'b0;
        check("R3 mirrors dark in capture", mirrors_off_o, 1);
        check("R3 shutter open in capture", shutter_open_o, 1);
        stop_i = stp;
        @(negedge clk);
        stop_i = 1'b0;
        repeat (x) @(negedge clk);
        pulse(cam_xfer_done_i);
        repeat (p) @(negedge clk);
        check("R4 no transfer before phase ready", link_start_o, 0);
        check("R3 mirrors dark while processing", mirrors_off_o, 1);
        map_ready_i = 1'b1;
        w = 0;
        while (!link_start_o && w < 50) begin
            @(negedge clk);
            w++;
        end
        map_ready_i = 1'b0;
        check("R4 transfer start seen", link_start_o, 1);
        check("R4 mirrors released at start", mirrors_off_o, 0);
        check("R5 shutter closed at start", shutter_open_o, 0);
        repeat (l) @(negedge clk);
        check("R4 start lasts one cycle", link_start_o, 0);
        link_done_i = 1'b1;
        @(negedge clk);
        link_done_i = 1'b0;
        t1 = cyc;
        check("R6 playback on link done", obs_trig_o, 1);
        check("R5 shutter closed in playback", shutter_open_o, 0);
        check("R8 latency value", int'(lat_cycles_o),
              ((t1 - t0) > LMAX) ? LMAX : (t1 - t0));
        n = 0;
        na = 0;
        while (obs_trig_o && n < 1000) begin
            n++;
            if (apd_gate_o) na++;
            play_cycles_i = PW'(pl + 5);
            @(negedge clk);
        end
        check("R6 playback length", n, (pl == 0) ? 1 : pl);
        check("R7 photodiode gate cycles", na, (pl == 0) ? 1 : pl);
        check("R7 gate low after playback", apd_gate_o, 0);
        check("R6 mirrors dark after playback", mirrors_off_o, 1);
        check("R6 shutter open after playback", shutter_open_o, 1);
    endtask

    // Camera activity while parked must start nothing.
    task automatic idle_probe(input string tag);
        int seen;
        seen = 0;
        cam_expose_i = 1'b1;
        @(negedge clk);
        cam_expose_i = 1'b0;
        pulse(cam_xfer_done_i);
        map_ready_i = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (link_start_o || !mirrors_off_o || !shutter_open_o) seen = 1;
        end
        map_ready_i = 1'b0;
        check(tag, seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset mirrors dark", mirrors_off_o, 1);
        check("R1 reset shutter open", shutter_open_o, 1);
        check("R1 reset no start", link_start_o, 0);
        check("R1 reset gates low", obs_trig_o | apd_gate_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 latency zero after reset", int'(lat_cycles_o), 0);
        check("R1 shutter open after reset", shutter_open_o, 1);

        pulse(start_i);
        check("R2 reference shutter closed", shutter_open_o, 0);
        check("R2 reference mirrors dark", mirrors_off_o, 1);
        @(negedge clk);
        check("R2 reference waits for frame", shutter_open_o, 0);
        pulse(cam_xfer_done_i);
        check("R2 armed shutter open", shutter_open_o, 1);

        for (int i = 0; i < NV; i++) begin
            run_iter(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 1'b0);
        end

        // R9: stop mid-iteration finishes it, then parks.
        run_iter(2, 1, 1, 2, 2, 1'b1);
        idle_probe("R9 idle after finished iteration");
        pulse(start_i);
        check("R9 restart goes through reference", shutter_open_o, 0);
        pulse(cam_xfer_done_i);
        check("R9 armed after restart", shutter_open_o, 1);
        // R9: stop while armed parks at once.
        pulse(stop_i);
        idle_probe("R9 idle after stop while armed");
        pulse(start_i);
        check("R9 second restart reference", shutter_open_o, 0);
        pulse(cam_xfer_done_i);
        run_iter(1, 0, 0, 1, 0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule